// File: doc/BRIEF.md
# Bus Cycle Progress Ordering Checker

This block watches one memory-bus master's cycle-progress handshake without driving anything. A cycle opens on either a cache-initiated start strobe or a snoop-initiated start strobe. While it is open, the monitor records the first arrival of each progress event: bus-guarantee, cacheability-window-end, snoop-window-end, data-transfer-start and cycle-ready. All five are active low. Each new arrival is compared against the events already recorded. Some pairs may legally arrive in the same clock. Others need strict precedence. Which checks apply depends on the cycle-type code latched at the start strobe.

A violation produces a one-clock pulse on that rule's bit of `viol_pulse` and sets the matching bit of `viol_sticky`. Only reset clears the sticky bits. `done_pulse` marks the end of every cycle.

Cycle-ready ends the bus cycle but not the snoop window. If a line fill or an allocating write-through reaches cycle-ready before its snoop-window-end, the pending window moves to a one-deep trailing slot. A new cycle may then start while that slot is still occupied.

Top module: `bus_order_monitor`

## Requirements
- R1: While reset is asserted, and after it is released, `viol_pulse`, `viol_sticky` and `done_pulse` are all zero until a tracked event changes them.
- R2: A start strobe seen with no cycle open opens a cycle, and events are recognized from the next clock onward. If both strobes are low in that clock, the cache start wins. Cycle-ready low while a cycle is open closes it, and `done_pulse` is high for exactly the clock after that sample.
- R3: In a cycle opened by the snoop start, only cycle-ready is tracked. Bus-guarantee and both window-end signals asserted during that cycle raise no violation.
- R4: Rule bit 0 pulses when cacheability-window-end first arrives in a cache cycle before any bus-guarantee. Arrival in the same clock as bus-guarantee is legal.
- R5: Rule bit 1 pulses when snoop-window-end first arrives in a cache cycle before bus-guarantee. For cycle-type codes 2'b01 (line fill) and 2'b10 (write-through with allocation), it also pulses when that arrival comes before cacheability-window-end. Arrival in the same clock as the predecessor is legal.
- R6: Rule bit 2 pulses when a cache cycle's cycle-ready arrives with no earlier data-transfer-start. Arrival in the same clock counts as a violation.
- R7: Rule bit 3 pulses when a cache cycle's cycle-ready arrives with no earlier bus-guarantee. Arrival in the same clock counts as a violation.
- R8: Rule bit 4 pulses when cycle-ready arrives, for cycle-type codes 2'b01 and 2'b10 only, with no earlier cacheability-window-end.
- R9: For cycle-type codes 2'b00 and 2'b11, both window-end signals may stay inactive for the whole cycle with no violation.
- R10: Consider a cycle of type 2'b01 or 2'b10 that reaches cycle-ready without snoop-window-end. Its window is held in a trailing slot. The next snoop-window-end closes that slot without error, even after a new cycle has started, and it is not checked against the new cycle.
- R11: Each violation pulse lasts one clock. The sticky bit of the same rule rises with the pulse and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cache_start_n | input | 1 | Cache-initiated cycle start strobe, active low |
| snoop_start_n | input | 1 | Snoop-initiated cycle start strobe, active low |
| cyc_type | input | 2 | Cycle type: 01 line fill, 10 write-through with allocation, others plain |
| grant_n | input | 1 | Bus-guarantee, active low |
| kwin_end_n | input | 1 | Cacheability-window-end, active low |
| swin_end_n | input | 1 | Snoop-window-end, active low |
| xfer_start_n | input | 1 | Data-transfer-start, active low |
| ready_n | input | 1 | Cycle-ready, active low |
| viol_pulse | output | 5 | One-clock violation pulse per rule (bits 0..4 as in R4..R8) |
| viol_sticky | output | 5 | Sticky violation bits, cleared by reset only |
| done_pulse | output | 1 | One-clock pulse after the clock that closes a cycle |

## Verification
The assertions assume that start strobes arrive only while no cycle is open. The one exception is the trailing slot, which does not block a start. They also assume that a strobe never appears in the same clock as the cycle-ready that closes the previous cycle. Every progress event in the stimulus is a single-clock low pulse. Those events fall in the clocks after the start strobe, so each event is recognized only at its intended arrival. Back-to-back cycles are always separated by at least one clock in which cycle-ready is sampled before the next start.

// File: rtl/bom_pkg.sv
package bom_pkg;
  localparam int unsigned TYPE_W = 2;
  localparam int unsigned NRULE  = 5;

  localparam logic [TYPE_W-1:0] CT_FILL    = 2'b01;
  localparam logic [TYPE_W-1:0] CT_WTALLOC = 2'b10;

  // rule bit positions in viol_pulse / viol_sticky
  localparam int unsigned RB_KW_BG  = 0;
  localparam int unsigned RB_SW_ORD = 1;
  localparam int unsigned RB_RDY_DT = 2;
  localparam int unsigned RB_RDY_BG = 3;
  localparam int unsigned RB_RDY_KW = 4;

  typedef struct packed {
    logic bg;
    logic kw;
    logic sw;
    logic dt;
  } seen_t;

  typedef struct packed {
    logic bg;
    logic kw;
    logic sw;
    logic dt;
    logic rdy;
  } evt_t;
endpackage

// File: rtl/bom_rst_sync.sv
module bom_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bom_cycle_track.sv
module bom_cycle_track
  import bom_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cstart,
  input  logic              sstart,
  input  logic [TYPE_W-1:0] ctype,
  input  evt_t              lvl,
  output logic              cyc_open,
  output logic              cyc_cache,
  output logic              need_win,
  output seen_t             seen,
  output evt_t              first,
  output logic              close
);
  logic  open_q, open_d;
  logic  cache_q, cache_d;
  logic  need_q, need_d;
  logic  trail_q, trail_d;
  seen_t seen_q, seen_d;
  logic  cache_act;
  logic  trail_hit;
  logic  type_needs;

  assign cache_act  = open_q & cache_q;
  assign type_needs = (ctype == CT_FILL) | (ctype == CT_WTALLOC);

  always_comb begin
    first.bg  = lvl.bg & cache_act & ~seen_q.bg;
    first.kw  = lvl.kw & cache_act & ~seen_q.kw;
    first.sw  = lvl.sw & cache_act & ~seen_q.sw & ~trail_q;
    first.dt  = lvl.dt & cache_act & ~seen_q.dt;
    first.rdy = lvl.rdy & open_q;
  end

  assign trail_hit = lvl.sw & trail_q;
  assign close     = first.rdy;

  always_comb begin
    open_d  = open_q;
    cache_d = cache_q;
    need_d  = need_q;
    seen_d  = seen_q;
    trail_d = trail_q;
    if (trail_hit) trail_d = 1'b0;
    if (close) begin
      open_d = 1'b0;
      seen_d = '0;
      if (cache_q && need_q && !seen_q.sw && !first.sw) trail_d = 1'b1;
    end else if (!open_q && (cstart || sstart)) begin
      open_d  = 1'b1;
      cache_d = cstart;
      need_d  = cstart & type_needs;
      seen_d  = '0;
    end else begin
      seen_d.bg = seen_q.bg | first.bg;
      seen_d.kw = seen_q.kw | first.kw;
      seen_d.sw = seen_q.sw | first.sw;
      seen_d.dt = seen_q.dt | first.dt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      cache_q <= 1'b0;
      need_q  <= 1'b0;
      seen_q  <= '0;
      trail_q <= 1'b0;
    end else begin
      open_q  <= open_d;
      cache_q <= cache_d;
      need_q  <= need_d;
      seen_q  <= seen_d;
      trail_q <= trail_d;
    end
  end

  assign cyc_open  = open_q;
  assign cyc_cache = cache_act;
  assign need_win  = need_q;
  assign seen      = seen_q;
endmodule

// File: rtl/bom_rule_eval.sv
module bom_rule_eval
  import bom_pkg::*;
(
  input  logic             cyc_cache,
  input  logic             need_win,
  input  logic             seen_bg,
  input  logic             seen_kw,
  input  logic             seen_dt,
  input  logic             first_bg,
  input  logic             first_kw,
  input  logic             first_sw,
  input  logic             first_rdy,
  output logic [NRULE-1:0] viol
);
  logic bg_by_now;
  logic kw_by_now;
  logic rdy_cache;

  // inclusive precedence: the current clock counts as "in time"
  assign bg_by_now = seen_bg | first_bg;
  assign kw_by_now = seen_kw | first_kw;
  // strict precedence: only earlier clocks count
  assign rdy_cache = first_rdy & cyc_cache;

  always_comb begin
    viol            = '0;
    viol[RB_KW_BG]  = first_kw & ~bg_by_now;
    viol[RB_SW_ORD] = first_sw & (~bg_by_now | (need_win & ~kw_by_now));
    viol[RB_RDY_DT] = rdy_cache & ~seen_dt;
    viol[RB_RDY_BG] = rdy_cache & ~seen_bg;
    viol[RB_RDY_KW] = rdy_cache & need_win & ~seen_kw;
  end
endmodule

// File: rtl/bom_flag_bank.sv
module bom_flag_bank #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] viol,
  output logic [N-1:0] pulse,
  output logic [N-1:0] sticky
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic pulse_q, pulse_d;
    logic sticky_q;
    logic sticky_en;

    always_comb begin
      pulse_d   = viol[i];
      sticky_en = viol[i] & ~sticky_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pulse_q  <= 1'b0;
        sticky_q <= 1'b0;
      end else begin
        pulse_q <= pulse_d;
        if (sticky_en) sticky_q <= 1'b1;
      end
    end

    assign pulse[i]  = pulse_q;
    assign sticky[i] = sticky_q;
  end
endmodule

// File: rtl/bus_order_monitor.sv
module bus_order_monitor
  import bom_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_start_n,
  input  logic              snoop_start_n,
  input  logic [TYPE_W-1:0] cyc_type,
  input  logic              grant_n,
  input  logic              kwin_end_n,
  input  logic              swin_end_n,
  input  logic              xfer_start_n,
  input  logic              ready_n,
  output logic [NRULE-1:0]  viol_pulse,
  output logic [NRULE-1:0]  viol_sticky,
  output logic              done_pulse
);
  logic             rst_i_n;
  evt_t             lvl;
  evt_t             first;
  seen_t            seen;
  logic             cyc_open;
  logic             cyc_cache;
  logic             need_win;
  logic             close;
  logic [NRULE-1:0] viol;
  logic             done_q, done_d;

  bom_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  always_comb begin
    lvl.bg  = ~grant_n;
    lvl.kw  = ~kwin_end_n;
    lvl.sw  = ~swin_end_n;
    lvl.dt  = ~xfer_start_n;
    lvl.rdy = ~ready_n;
  end

  bom_cycle_track u_track (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .cstart    (~cache_start_n),
    .sstart    (~snoop_start_n),
    .ctype     (cyc_type),
    .lvl       (lvl),
    .cyc_open  (cyc_open),
    .cyc_cache (cyc_cache),
    .need_win  (need_win),
    .seen      (seen),
    .first     (first),
    .close     (close)
  );

  bom_rule_eval u_rules (
    .cyc_cache (cyc_cache),
    .need_win  (need_win),
    .seen_bg   (seen.bg),
    .seen_kw   (seen.kw),
    .seen_dt   (seen.dt),
    .first_bg  (first.bg),
    .first_kw  (first.kw),
    .first_sw  (first.sw),
    .first_rdy (first.rdy),
    .viol      (viol)
  );

  bom_flag_bank #(.N(NRULE)) u_flags (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .viol   (viol),
    .pulse  (viol_pulse),
    .sticky (viol_sticky)
  );

  always_comb done_d = close;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) done_q <= 1'b0;
    else          done_q <= done_d;
  end

  assign done_pulse = done_q;
endmodule

// File: rtl/bom_checker.sv
module bom_checker
  import bom_pkg::*;
(
  input logic             clk,
  input logic             rst_i_n,
  input logic             grant_n,
  input logic             kwin_end_n,
  input logic             xfer_start_n,
  input logic             ready_n,
  input logic             cyc_open,
  input logic             cyc_cache,
  input logic             dt_seen,
  input logic [NRULE-1:0] viol_pulse,
  input logic [NRULE-1:0] viol_sticky,
  input logic             done_pulse
);
  assert_close_done_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cyc_open && !ready_n) |=> done_pulse);

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    done_pulse |=> !done_pulse);

  assert_snoop_quiet_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cyc_open && !cyc_cache) |=> (viol_pulse == '0));

  assert_kw_with_bg_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cyc_cache && !grant_n && !kwin_end_n) |=> !viol_pulse[RB_KW_BG]);

  assert_rdy_strict_dt_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cyc_cache && !ready_n && !dt_seen) |=> viol_pulse[RB_RDY_DT]);

  for (genvar i = 0; i < NRULE; i++) begin : g_stk
    assert_pulse_sets_sticky_R11: assert property (@(posedge clk) disable iff (!rst_i_n)
      viol_pulse[i] |-> viol_sticky[i]);
    assert_sticky_holds_R11: assert property (@(posedge clk) disable iff (!rst_i_n)
      viol_sticky[i] |=> viol_sticky[i]);
  end
endmodule

bind bus_order_monitor bom_checker u_chk (
  .clk          (clk),
  .rst_i_n      (rst_i_n),
  .grant_n      (grant_n),
  .kwin_end_n   (kwin_end_n),
  .xfer_start_n (xfer_start_n),
  .ready_n      (ready_n),
  .cyc_open     (cyc_open),
  .cyc_cache    (cyc_cache),
  .dt_seen      (seen.dt),
  .viol_pulse   (viol_pulse),
  .viol_sticky  (viol_sticky),
  .done_pulse   (done_pulse)
);

// File: tb/test_bus_order_monitor.sv
`timescale 1ns/1ps
module test_bus_order_monitor;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cache_start_n, snoop_start_n;
  logic [1:0] cyc_type;
  logic       grant_n, kwin_end_n, swin_end_n, xfer_start_n, ready_n;
  logic [4:0] viol_pulse, viol_sticky;
  logic       done_pulse;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bus_order_monitor i_bus_order_monitor (
    .clk(clk), .rst_n(rst_n),
    .cache_start_n(cache_start_n), .snoop_start_n(snoop_start_n),
    .cyc_type(cyc_type), .grant_n(grant_n), .kwin_end_n(kwin_end_n),
    .swin_end_n(swin_end_n), .xfer_start_n(xfer_start_n), .ready_n(ready_n),
    .viol_pulse(viol_pulse), .viol_sticky(viol_sticky), .done_pulse(done_pulse)
  );

  // vector: {cs, ss, type[1:0], ev{bg,kw,sw,dt,rdy}, exp_pulse[4:0], exp_done}
  localparam int NV = 36;
  localparam logic [14:0] VEC [NV] = '{
    {1'b1,1'b0,2'b01,5'b00000,5'b00000,1'b0}, // R2 open fill
    {1'b0,1'b0,2'b00,5'b11000,5'b00000,1'b0}, // R4 bg+kw same clock legal
    {1'b0,1'b0,2'b00,5'b00110,5'b00000,1'b0}, // R5 sw after kw
    {1'b0,1'b0,2'b00,5'b00001,5'b00000,1'b1}, // R2 close
    {1'b0,1'b1,2'b00,5'b00000,5'b00000,1'b0}, // R3 snoop open
    {1'b0,1'b0,2'b00,5'b11100,5'b00000,1'b0}, // R3 stray events ignored
    {1'b0,1'b0,2'b00,5'b00001,5'b00000,1'b1}, // R3 ready alone
    {1'b1,1'b0,2'b01,5'b00000,5'b00000,1'b0},
    {1'b0,1'b0,2'b00,5'b01000,5'b00001,1'b0}, // R4 kw before bg
    {1'b0,1'b0,2'b00,5'b10010,5'b00000,1'b0},
    {1'b0,1'b0,2'b00,5'b00100,5'b00000,1'b0},
    {1'b0,1'b0,2'b00,5'b00001,5'b00000,1'b1},
    {1'b1,1'b0,2'b00,5'b00000,5'b00000,1'b0}, // R9 plain type
    {1'b0,1'b0,2'b00,5'b10000,5'b00000,1'b0},
    {1'b0,1'b0,2'b00,5'b00011,5'b00100,1'b1}, // R6 dt with ready; R9 no kw rule
    {1'b1,1'b0,2'b10,5'b00000,5'b00000,1'b0},
    {1'b0,1'b0,2'b00,5'b00010,5'b00000,1'b0},
    {1'b0,1'b0,2'b00,5'b00001,5'b11000,1'b1}, // R7 R8 ready w/o bg, kw
    {1'b0,1'b0,2'b00,5'b00100,5'b00000,1'b0}, // R10 sw after ready
    {1'b1,1'b0,2'b01,5'b00000,5'b00000,1'b0},
    {1'b0,1'b0,2'b00,5'b10000,5'b00000,1'b0},
    {1'b0,1'b0,2'b00,5'b00100,5'b00010,1'b0}, // R5 sw before kw
    {1'b0,1'b0,2'b00,5'b01010,5'b00000,1'b0},
    {1'b0,1'b0,2'b00,5'b00001,5'b00000,1'b1},
    {1'b1,1'b0,2'b01,5'b00000,5'b00000,1'b0},
    {1'b0,1'b0,2'b00,5'b11010,5'b00000,1'b0},
    {1'b0,1'b0,2'b00,5'b00001,5'b00000,1'b1}, // R10 slot fills
    {1'b1,1'b0,2'b00,5'b00000,5'b00000,1'b0}, // R10 start while slot busy
    {1'b0,1'b0,2'b00,5'b00100,5'b00000,1'b0}, // R10 sw to slot, not checked
    {1'b0,1'b0,2'b00,5'b10010,5'b00000,1'b0},
    {1'b0,1'b0,2'b00,5'b00001,5'b00000,1'b1},
    {1'b1,1'b0,2'b00,5'b00000,5'b00000,1'b0},
    {1'b0,1'b0,2'b00,5'b00100,5'b00010,1'b0}, // R5 sw before bg, plain type
    {1'b0,1'b0,2'b00,5'b10010,5'b00000,1'b0},
    {1'b0,1'b0,2'b00,5'b00001,5'b00000,1'b1},
    {1'b0,1'b0,2'b00,5'b00000,5'b00000,1'b0}  // R11 pulse gone
  };
  localparam int VREQ [NV] = '{2,4,5,2,3,3,3,4,4,4,5,2,9,9,6,7,7,7,10,5,5,5,5,2,
                               10,10,10,10,10,10,10,5,5,5,5,11};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cache_start_n = 1'b1; snoop_start_n = 1'b1; cyc_type = 2'b00;
    grant_n = 1'b1; kwin_end_n = 1'b1; swin_end_n = 1'b1;
    xfer_start_n = 1'b1; ready_n = 1'b1;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 pulse in reset", 32'(viol_pulse), 0);
    check("R1 sticky in reset", 32'(viol_sticky), 0);
    check("R1 done in reset", 32'(done_pulse), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R1 sticky after release", 32'(viol_sticky), 0);

    for (int i = 0; i < NV; i++) begin
      logic [14:0] v;
      v = VEC[i];
      cache_start_n = ~v[14]; snoop_start_n = ~v[13]; cyc_type = v[12:11];
      grant_n = ~v[10]; kwin_end_n = ~v[9]; swin_end_n = ~v[8];
      xfer_start_n = ~v[7]; ready_n = ~v[6];
      @(posedge clk);
      #1;
      idle_inputs();
      check($sformatf("R%0d vec %0d pulse", VREQ[i], i), 32'(viol_pulse), 32'(v[5:1]));
      check($sformatf("R%0d vec %0d done", VREQ[i], i), 32'(done_pulse), 32'(v[0]));
    end

    check("R11 sticky collects all rules", 32'(viol_sticky), 32'h1f);
    repeat (3) @(posedge clk);
    #1;
    check("R11 sticky held", 32'(viol_sticky), 32'h1f);

    rst_n = 1'b0;
    #1;
    check("R1 sticky cleared by reset", 32'(viol_sticky), 0);
    @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R1 outputs quiet after reset", 32'({viol_pulse, viol_sticky, done_pulse}), 0);

    finish_run();
  end
endmodule